// File: doc/BRIEF.md
# Memory Bus Cycle Sequencer

This block sits between a requester and a byte-addressed memory bus. It turns one accepted request into a bus transaction. A transaction is either a single read, a single write, or a burst of four reads. Every bus operation walks through three phases: an address phase, a wait phase and a closing phase. With fast memory an operation therefore takes three clocks. A slow memory holds its ready input low to stretch the wait phase one clock at a time.

The request side is a valid/ready handshake. A request transfers on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while the sequencer is idle, so the requester simply holds its request until it is taken. The response side has no back-pressure. Each read word appears on `rsp_data` for one clock with `rsp_valid`, and `done` marks the end of the transaction; the requester must take a word in the clock it is offered. On the bus side the data bus is split into an outgoing half with an output enable and an incoming half, so the pads can form a shared bus outside this block.

Top module: `mem_bus_cycle_ctrl`

## Requirements
- R1: While reset is held and while idle, `bus_rd`, `bus_wr`, `bus_wdata_oe`, `busy`, `rsp_valid` and `done` are all low, and `req_ready` is high.
- R2: A read with ready high in its wait phase holds `bus_rd` high for exactly three clocks, beginning in the clock after acceptance. `bus_addr` equals the request address throughout. The word on `bus_rdata` in the third clock is returned on `rsp_data` with `rsp_valid` and `done` in the following clock.
- R3: A write drives `bus_addr` and `bus_wdata` with `bus_wdata_oe` high for three clocks from the clock after acceptance. `bus_wr` is high only in the second of them, so it rises only after address and data are already on the bus. `done` pulses in the next clock and `rsp_valid` stays low.
- R4: Each clock in which `bus_ready` is low during the wait phase adds one clock to the operation. The active strobe and the address are held through the added clocks.
- R5: A request with `req_burst`=1 and `req_write`=0 runs four back-to-back reads. The word-index bits (address bits just above the byte-offset bits, two bits wide) start at the request value and increment modulo 4, while all other address bits stay unchanged. Each word is returned with a `rsp_valid` pulse, and `done` pulses only together with the fourth word.
- R6: `req_ready` is low from acceptance until the transaction completes. A `req_valid` presented during that time has no effect on the bus, and no operation starts from it.
- R7: `bus_wdata_oe` is high only during write transactions, and `bus_rd` and `bus_wr` are never high together.
- R8: `busy` is high in every clock from the one after acceptance up to the last clock of the last operation, and is low in the clock that shows `done`.
- R9: For a write request, `req_burst` is ignored and a single write is performed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = four-word read burst (reads only) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Transaction in progress |
| rsp_valid | output | 1 | Read word on rsp_data this clock |
| rsp_data | output | DATA_W | Read word |
| done | output | 1 | One-clock pulse at transaction end |
| bus_addr | output | ADDR_W | Memory address bus |
| bus_wdata | output | DATA_W | Outgoing data bus |
| bus_wdata_oe | output | 1 | Output enable for the outgoing data bus |
| bus_rdata | input | DATA_W | Incoming data bus |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_ready | input | 1 | Memory ready; low inserts a wait state |

## Verification
The hardest case to reach is the interaction of wait states with timing. The operation length, the strobe shape and the capture clock must all shift by exactly the number of low-ready clocks, and in a burst the stretch must land only on the operation where ready was held low. The bench models the memory with a ready counter that is reloaded whenever the bus goes quiet. This lets it sweep zero to three wait states on reads and writes, and add waits to bursts started at every word index of the four-word block. It also injects a request in the middle of a transaction to show that a busy sequencer never starts it.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_WAIT = 2'd2,
    PH_DONE = 2'd3
  } phase_t;
endpackage

// File: rtl/mbc_addr_step.sv
// Next word address inside an aligned block of 2**BEAT_W words.
module mbc_addr_step #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 1,
  parameter int BEAT_W = 2
) (
  input  logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] next_addr
);
  logic [BEAT_W-1:0] idx;

  always_comb begin
    idx       = cur_addr[OFF_W +: BEAT_W] + 1'b1;
    next_addr = cur_addr;
    next_addr[OFF_W +: BEAT_W] = idx;
  end
endmodule

// File: rtl/mbc_sequencer.sv
module mbc_sequencer
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_write,
  input  logic              req_burst,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              bus_ready,
  output phase_t            phase,
  output logic              is_wr,
  output logic              last_beat,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata
);
  localparam int OFF_W = (DATA_W / 8 > 1) ? $clog2(DATA_W / 8) : 0;

  logic              is_burst;
  logic [BEAT_W-1:0] beat;
  logic [ADDR_W-1:0] step_addr;

  mbc_addr_step #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BEAT_W(BEAT_W)) u_step (
    .cur_addr (cur_addr),
    .next_addr(step_addr)
  );

  assign last_beat = !is_burst || (beat == {BEAT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      is_wr     <= 1'b0;
      is_burst  <= 1'b0;
      beat      <= '0;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (accept) begin
          phase     <= PH_ADDR;
          is_wr     <= req_write;
          is_burst  <= req_burst && !req_write;
          beat      <= '0;
          cur_addr  <= req_addr;
          cur_wdata <= req_wdata;
        end
        PH_ADDR: phase <= PH_WAIT;
        PH_WAIT: if (bus_ready) phase <= PH_DONE;
        PH_DONE: begin
          if (last_beat) begin
            phase <= PH_IDLE;
          end else begin
            phase    <= PH_ADDR;
            beat     <= beat + 1'b1;
            cur_addr <= step_addr;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbc_response.sv
module mbc_response #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_end,
  input  logic              is_wr,
  input  logic              last_beat,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      done      <= 1'b0;
    end else begin
      rsp_valid <= beat_end && !is_wr;
      done      <= beat_end && last_beat;
      if (beat_end && !is_wr) rsp_data <= bus_rdata;
    end
  end
endmodule

// File: rtl/mem_bus_cycle_ctrl.sv
module mem_bus_cycle_ctrl
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_burst,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              done,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wdata_oe,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rd,
  output logic              bus_wr,
  input  logic              bus_ready
);
  phase_t            phase;
  logic              is_wr;
  logic              last_beat;
  logic              active;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;

  assign active    = (phase != PH_IDLE);
  assign busy      = active;
  assign req_ready = !active;

  mbc_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEAT_W(BEAT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (req_valid && req_ready),
    .req_write(req_write),
    .req_burst(req_burst),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .bus_ready(bus_ready),
    .phase    (phase),
    .is_wr    (is_wr),
    .last_beat(last_beat),
    .cur_addr (cur_addr),
    .cur_wdata(cur_wdata)
  );

  mbc_response #(.DATA_W(DATA_W)) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat_end (phase == PH_DONE),
    .is_wr    (is_wr),
    .last_beat(last_beat),
    .bus_rdata(bus_rdata),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data),
    .done     (done)
  );

  assign bus_addr     = cur_addr;
  assign bus_wdata    = cur_wdata;
  assign bus_wdata_oe = active && is_wr;
  assign bus_rd       = active && !is_wr;
  assign bus_wr       = is_wr && (phase == PH_WAIT);
endmodule

// File: rtl/mbc_checker.sv
module mbc_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              busy,
  input logic              rsp_valid,
  input logic              done,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wdata_oe,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              bus_ready
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_rd && !bus_wr && !bus_wdata_oe));

  p_wr_after_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr) |-> ($past(bus_wdata_oe) && $stable(bus_addr)));

  p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_ready) |=> (bus_wr && $stable(bus_addr)));

  p_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  p_oe_not_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> !bus_wdata_oe);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_rsp_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !bus_wdata_oe);
endmodule

bind mem_bus_cycle_ctrl mbc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .busy        (busy),
  .rsp_valid   (rsp_valid),
  .done        (done),
  .bus_addr    (bus_addr),
  .bus_wdata_oe(bus_wdata_oe),
  .bus_rd      (bus_rd),
  .bus_wr      (bus_wr),
  .bus_ready   (bus_ready)
);

// File: tb/mem_bus_cycle_ctrl_bench.sv
module mem_bus_cycle_ctrl_bench;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic          req_burst = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          busy, rsp_valid, done;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_wdata_oe, bus_rd, bus_wr;
  logic [DW-1:0] bus_rdata;
  logic          bus_ready;

  int nchecks = 0;
  int nerrors = 0;
  int nwait = 0;
  int ready_cnt = 1;

  always #5 clk = ~clk;

  mem_bus_cycle_ctrl u_mem_bus_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_burst(req_burst), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .done(done), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe), .bus_rdata(bus_rdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ready(bus_ready)
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] base, input int k);
    logic [1:0] idx;
    logic [AW-1:0] r;
    idx = base[2:1] + k[1:0];
    r = base;
    r[2:1] = idx;
    return r;
  endfunction

  // memory model: data follows address, ready low for nwait clocks of the wait phase
  assign bus_rdata = mem_word(bus_addr);
  assign bus_ready = (ready_cnt == 0);
  always @(posedge clk) begin
    if (!(bus_rd || bus_wr || bus_wdata_oe)) ready_cnt <= nwait + 1;
    else if (ready_cnt != 0) ready_cnt <= ready_cnt - 1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchecks++;
    if (!ok) begin
      nerrors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_txn(input bit wr, input bit burst, input logic [AW-1:0] addr,
                         input logic [DW-1:0] wdata, input int waits, input bit inject);
    int cyc = 0, rd_n = 0, wr_n = 0, oe_n = 0, rsp_n = 0, bad_addr = 0, bad_data = 0;
    int bad_busy = 0, first_wr = -1;
    bit eff_burst;
    eff_burst = burst && !wr;
    nwait = waits;
    @(negedge clk);
    chk(req_ready, "R1 ready while idle", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_burst = burst;
    req_addr = addr; req_wdata = wdata;
    @(posedge clk);
    #1 req_valid = 1'b0;
    forever begin
      @(negedge clk);
      if (inject && cyc == 1) begin
        req_valid = 1'b1; req_write = 1'b1; req_burst = 1'b0;
        req_addr = ~addr; req_wdata = 16'hFFFF;
      end
      if (inject && cyc == 2) req_valid = 1'b0;
      if (rsp_valid) begin
        if (rsp_data !== mem_word(beat_addr(addr, rsp_n))) bad_data++;
        rsp_n++;
      end
      if (bus_rd) rd_n++;
      if (bus_wr) begin
        wr_n++;
        if (first_wr < 0) first_wr = cyc;
      end
      if (bus_wdata_oe) begin
        oe_n++;
        if (bus_wdata !== wdata) bad_data++;
      end
      if ((bus_rd || bus_wdata_oe) &&
          bus_addr !== (eff_burst ? beat_addr(addr, rsp_n) : addr)) bad_addr++;
      if (done) break;
      if (!busy || req_ready) bad_busy++;
      if (cyc > 100) break;
      @(posedge clk);
      cyc++;
    end
    chk(done, "R8 done seen", done, 1);
    chk(!busy, "R8 busy low with done", busy, 0);
    chk(bad_busy == 0, "R8 busy/R6 ready during txn", bad_busy, 0);
    chk(bad_addr == 0, "R2 R5 bus address", bad_addr, 0);
    chk(bad_data == 0, "R2 R3 R5 data", bad_data, 0);
    if (wr) begin
      chk(cyc == 3 + waits, "R3 R4 write length", cyc, 3 + waits);
      chk(wr_n == 1 + waits, "R3 R4 write strobe clocks", wr_n, 1 + waits);
      chk(first_wr == 1, "R3 strobe after setup", first_wr, 1);
      chk(oe_n == 3 + waits && rd_n == 0, "R7 oe only on write", oe_n, 3 + waits);
      chk(rsp_n == 0, "R3 no rsp_valid on write", rsp_n, 0);
      if (burst) chk(rsp_n == 0 && cyc == 3 + waits, "R9 burst ignored for write", cyc, 3 + waits);
    end else begin
      int beats;
      beats = eff_burst ? 4 : 1;
      chk(cyc == 3 * beats + waits, "R2 R4 R5 read length", cyc, 3 * beats + waits);
      chk(rd_n == 3 * beats + waits, "R2 R4 read strobe clocks", rd_n, 3 * beats + waits);
      chk(rsp_n == beats, "R5 word count", rsp_n, beats);
      chk(oe_n == 0 && wr_n == 0, "R7 no drive on read", oe_n + wr_n, 0);
      if (inject) chk(wr_n == 0, "R6 request while busy ignored", wr_n, 0);
    end
    @(negedge clk);
    chk(!busy && !bus_rd && !bus_wr && !bus_wdata_oe && !done && !rsp_valid,
        "R1 quiet after txn", {busy, bus_rd, bus_wr, bus_wdata_oe}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!bus_rd && !bus_wr && !bus_wdata_oe && !busy && !done && !rsp_valid,
        "R1 reset state", {bus_rd, bus_wr, bus_wdata_oe, busy}, 0);
    chk(req_ready, "R1 ready in reset", req_ready, 1);
    rst_n = 1'b1;
    for (int w = 0; w < 4; w++) begin
      run_txn(1'b0, 1'b0, 16'h1234 + 16'(w * 2), '0, w, 1'b0);
      run_txn(1'b1, 1'b0, 16'hA0F0 - 16'(w * 6), 16'hC3A5 ^ 16'(w), w, 1'b0);
    end
    for (int s = 0; s < 4; s++) begin
      run_txn(1'b0, 1'b1, 16'h4F00 | 16'(s * 2) | 16'h0010, '0, 0, 1'b0);
      run_txn(1'b0, 1'b1, 16'h7FF8 | 16'(s * 2), '0, 2, 1'b0);
    end
    run_txn(1'b1, 1'b1, 16'h0102, 16'h55AA, 1, 1'b0);
    run_txn(1'b0, 1'b0, 16'h3344, '0, 2, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchecks++;
    nerrors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end
endmodule